// File: doc/BRIEF.md
# Shared Word-Address Pointer with Array and Identity Regions

This block keeps the single word-address pointer that a two-wire serial memory front end uses for both its 8192-byte data array and a small 32-byte read-only identity region. The protocol engine loads the pointer from a received word address, together with a flag that says which region the access targets. It then steps the pointer once per byte transferred. Write steps and read steps follow different wrap rules. The pointer keeps its value between transactions, so a later current-address access continues from one past the last byte touched.

The block also picks the byte that a read returns. In the main array region it forwards the byte supplied by the external storage. In the identity region it returns one byte of a 128-bit constant given as a parameter, zeros past that value, or a fixed filler when the address pattern is not valid. Bus protocol handling and storage timing are not part of this block.

Top module: `addr_pointer_regions`

## Requirements
- R1: After reset the pointer reads 0 and the region output is 0, which means the main array.
- R2: A load strobe copies the 13-bit address and the region flag into the pointer on the next clock edge. A load wins over any step strobe in the same cycle.
- R3: A write step adds one to pointer bits 4:0 modulo 32 and leaves bits 12:5 unchanged. This applies in both regions. When both step strobes are high without a load, the write step applies.
- R4: A read step in the main array region adds one to the full 13-bit pointer, so 0x1FFF is followed by 0x0000.
- R5: A read step in the identity region adds one to bits 4:0 modulo 32 and leaves bits 12:5 unchanged, so byte 31 is followed by byte 0.
- R6: In a cycle with no strobe, the pointer and the region are unchanged.
- R7: In the main array region, the read byte equals the array data input.
- R8: In the identity region with pointer bits 11:10 equal to binary 10, and bits 4:0 = k below 16, the read byte is bits 127-8k down to 120-8k of the identity parameter. Bytes are taken most significant first. Loading 0x0800 selects byte 0.
- R9: In the identity region with bits 11:10 equal to binary 10 and bits 4:0 at 16 or above, the read byte is 0x00.
- R10: In the identity region with bits 11:10 other than binary 10, the read byte is 0xFF.
- R11: The page index output always equals pointer bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load the pointer from load_addr and load_id |
| load_addr | input | 13 | Word address to load |
| load_id | input | 1 | Region of the load: 1 = identity, 0 = main array |
| wr_step | input | 1 | Advance the pointer after a written byte |
| rd_step | input | 1 | Advance the pointer after a read byte |
| arr_data | input | 8 | Byte from main array storage at the current pointer |
| ptr_addr | output | 13 | Current pointer |
| page_index | output | 5 | Byte position within the current 32-byte page |
| in_id | output | 1 | Current region: 1 = identity |
| rd_data | output | 8 | Byte returned for the current pointer and region |

## Verification
On every cycle, the embedded assertions check the step arithmetic: the page-row bits stay fixed on write steps and identity reads, the full wrap at the top of the array happens, loads take effect, idle cycles hold the pointer, and the zero and 0xFF data cases are correct. Only the bench scenarios, compared against a behavioural model, can show that the identity bytes come out in the right order. The same applies to priority between simultaneous strobes, and to the pointer persisting across separate load-then-step sequences.

// File: rtl/addr_pointer_regions.sv
module addr_pointer_regions #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5,
  parameter int ID_W = 128,
  parameter logic [127:0] ID_VALUE = 128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_id,
  input  logic              wr_step,
  input  logic              rd_step,
  input  logic [7:0]        arr_data,
  output logic [ADDR_W-1:0] ptr_addr,
  output logic [PAGE_W-1:0] page_index,
  output logic              in_id,
  output logic [7:0]        rd_data
);
  localparam int ID_BYTES = ID_W / 8;
  localparam int SEL_LO = 10;
  localparam logic [1:0] SEL_OK = 2'b10;

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              id_q, id_d;
  logic [PAGE_W-1:0] low_inc;
  logic [7:0]        id_byte;

  assign low_inc = ptr_q[PAGE_W-1:0] + 1'b1;

  always_comb begin
    ptr_d = ptr_q;
    id_d  = id_q;
    if (load_en) begin
      ptr_d = load_addr;
      id_d  = load_id;
    end else if (wr_step || (rd_step && id_q)) begin
      ptr_d = {ptr_q[ADDR_W-1:PAGE_W], low_inc};
    end else if (rd_step) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      id_q  <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      id_q  <= id_d;
    end
  end

  always_comb begin
    id_byte = 8'h00;
    if (ptr_q[SEL_LO+1:SEL_LO] != SEL_OK)
      id_byte = 8'hFF;
    else if (int'(ptr_q[PAGE_W-1:0]) < ID_BYTES)
      id_byte = ID_VALUE[ID_W-1-8*int'(ptr_q[PAGE_W-1:0]) -: 8];
  end

  assign ptr_addr   = ptr_q;
  assign page_index = ptr_q[PAGE_W-1:0];
  assign in_id      = id_q;
  assign rd_data    = id_q ? id_byte : arr_data;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (ptr_addr == $past(load_addr)) && (in_id == $past(load_id)));

  assert_write_row_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_step && !load_en) |=> (ptr_addr[ADDR_W-1:PAGE_W] == $past(ptr_addr[ADDR_W-1:PAGE_W]))
      && (page_index == $past(page_index) + 1'b1));

  assert_read_top_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && !wr_step && !load_en && !in_id && (&ptr_addr)) |=> (ptr_addr == '0));

  assert_id_read_row_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && !wr_step && !load_en && in_id) |=>
      (ptr_addr[ADDR_W-1:PAGE_W] == $past(ptr_addr[ADDR_W-1:PAGE_W])) && in_id);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !wr_step && !rd_step) |=> $stable(ptr_addr) && $stable(in_id));

  assert_main_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_id |-> rd_data == arr_data);

  assert_id_tail_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_id && ptr_addr[SEL_LO+1:SEL_LO] == SEL_OK && int'(page_index) >= ID_BYTES) |-> rd_data == 8'h00);

  assert_bad_pattern_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_id && ptr_addr[SEL_LO+1:SEL_LO] != SEL_OK) |-> rd_data == 8'hFF);
endmodule

// File: tb/addr_pointer_regions_test.sv
module addr_pointer_regions_test;
  localparam logic [127:0] IDV = 128'hA1B2_C3D4_E5F6_0718_293A_4B5C_6D7E_8F90;

  logic clk = 0, rst_n = 0;
  logic load_en = 0, load_id = 0, wr_step = 0, rd_step = 0;
  logic [12:0] load_addr = 0;
  logic [7:0] arr_data = 0;
  logic [12:0] ptr_addr;
  logic [4:0] page_index;
  logic in_id;
  logic [7:0] rd_data;

  int compared = 0, mismatched = 0;
  int m_ptr = 0;
  bit m_id = 0;

  always #5 clk = ~clk;

  addr_pointer_regions #(.ID_VALUE(IDV)) uut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr), .load_id(load_id),
    .wr_step(wr_step), .rd_step(rd_step), .arr_data(arr_data), .ptr_addr(ptr_addr),
    .page_index(page_index), .in_id(in_id), .rd_data(rd_data));

  function automatic int exp_data();
    int b;
    if (!m_id) return int'(arr_data);
    if (((m_ptr / 1024) % 4) != 2) return 255;
    b = m_ptr % 32;
    if (b >= 16) return 0;
    return int'((IDV >> (8 * (15 - b))) & 128'hFF);
  endfunction

  task automatic compare(input string tag);
    compared++;
    if (int'(ptr_addr) != m_ptr) begin
      mismatched++;
      $display("FAIL %s ptr_addr got %h exp %h", tag, ptr_addr, m_ptr);
    end
    compared++;
    if (in_id != m_id) begin
      mismatched++;
      $display("FAIL %s in_id got %0d exp %0d", tag, in_id, m_id);
    end
    compared++;
    if (int'(page_index) != m_ptr % 32) begin
      mismatched++;
      $display("FAIL %s R11 page_index got %h exp %h", tag, page_index, m_ptr % 32);
    end
    compared++;
    if (int'(rd_data) != exp_data()) begin
      mismatched++;
      $display("FAIL %s rd_data got %h exp %h", tag, rd_data, exp_data());
    end
  endtask

  task automatic cyc(input bit ld, input int addr, input bit idf, input bit wr, input bit rd,
                     input int arr, input string tag);
    load_en = ld; load_addr = 13'(addr); load_id = idf; wr_step = wr; rd_step = rd;
    arr_data = 8'(arr);
    @(posedge clk);
    if (ld) begin m_ptr = addr % 8192; m_id = idf; end
    else if (wr || (rd && m_id)) m_ptr = (m_ptr / 32) * 32 + ((m_ptr + 1) % 32);
    else if (rd) m_ptr = (m_ptr + 1) % 8192;
    @(negedge clk);
    load_en = 0; wr_step = 0; rd_step = 0;
    compare(tag);
  endtask

  bit finished = 0;
  initial begin
    #2_000_000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1 reset");
    cyc(0, 0, 0, 0, 0, 8'h3C, "R1 R7 idle after reset");
    cyc(1, 13'h1234, 0, 0, 0, 8'h5A, "R2 load main");
    cyc(0, 0, 0, 0, 0, 8'hC3, "R6 hold");
    cyc(1, 13'h0777, 0, 1, 1, 8'h11, "R2 load beats steps");
    cyc(1, 13'h003E, 0, 0, 0, 8'h22, "R2 load");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0, 8'h40 + i, "R3 write page wrap");
    cyc(0, 0, 0, 1, 1, 8'h33, "R3 write wins over read");
    cyc(1, 13'h1FFE, 0, 0, 0, 8'h44, "R2 load top");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 8'h60 + i, "R4 read full wrap");
    cyc(1, 13'h005F, 0, 0, 0, 8'h00, "R2 load");
    cyc(0, 0, 0, 0, 1, 8'h77, "R4 read crosses page");
    cyc(0, 0, 0, 0, 0, 8'h88, "R6 hold across idle");
    cyc(1, 13'h0800, 1, 0, 0, 0, "R8 load id byte 0");
    for (int i = 0; i < 35; i++) cyc(0, 0, 0, 0, 1, 8'hEE, i < 15 ? "R8 id bytes" : "R9 R5 id zeros and wrap");
    cyc(0, 0, 0, 1, 0, 8'hEE, "R3 write step in id region");
    cyc(1, 13'h1810, 1, 0, 0, 0, "R9 id byte 16 upper bits ignored");
    cyc(1, 13'h0C05, 1, 0, 0, 0, "R10 bad pattern 11");
    cyc(1, 13'h0003, 1, 0, 0, 0, "R10 bad pattern 00");
    cyc(0, 0, 0, 0, 1, 0, "R10 R5 bad pattern read step");
    cyc(1, 13'h081F, 1, 0, 0, 0, "R9 id byte 31");
    cyc(0, 0, 0, 0, 1, 0, "R5 id wrap to byte 0");
    cyc(1, 13'h0ABC, 0, 0, 0, 8'h99, "R7 back to main");
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule